// File: doc/BRIEF.md
# Two-Slot Alternating Transmit Buffer

This block sits between a host and a MAC transmit path. It owns a packet store split into two equal slots. The host streams packet bytes into the slot currently open for filling. It loads the packet byte count into two 8-bit length registers and then sets a request bit to launch that slot towards the MAC. The slot in use for filling flips at every accepted launch, so packets always leave in the order first slot, second slot, first slot, and so on. The host may fill the idle slot while the other slot is still draining.

The request bit reads back as a busy flag that the host can poll. A launch with an unusable length is refused at once. Each finished packet produces a single-cycle completion pulse. The outgoing byte stream uses valid/ready. A byte is presented with `out_valid` high and is held, with `out_data` and `out_last` unchanged, until `out_ready` is seen high at a clock edge. The host write port is also valid/ready, and the block applies back-pressure on it.

Top module: `tx2_slot_buffer`

## Requirements
- R1: After reset `req_busy`, `out_valid` and `tx_done` are 0, `mem_in_ready` is 1, and the first slot (slot 0) is the one open for filling.
- R2: A register write with `reg_addr` 0 loads bits 7:0 of the byte count, and `reg_addr` 1 loads bits 15:8. The count used at launch is the full 16-bit value, so a high byte of 1 with a low byte of 2 means 258.
- R3: A register write with `reg_addr` 2 and `reg_wdata[0]`=1 while `req_busy` is 0 and the count is valid launches the slot open for filling. `req_busy` is 1 from the next cycle, and the first byte is valid two cycles after the launch edge. Bytes leave in the order they were written, starting at the slot's first byte, and exactly count bytes are sent.
- R4: A launch write while `req_busy` is 1 is ignored. The packet in flight keeps its original count and content, even if the length registers are rewritten.
- R5: `req_busy` stays 1 until the handshake of the final byte. It then clears in the following cycle, and in that same cycle `tx_done` is high for exactly one cycle.
- R6: A launch with a count of 0, or a count above the slot size, sends nothing and produces no `tx_done`. `req_busy` stays 0. The slot open for filling and its write position are unchanged.
- R7: Each accepted launch switches filling to the other slot and restarts filling at that slot's first byte, so slots are used strictly in alternation.
- R8: Bytes written while a packet is being sent go into the other slot and do not disturb the packet in flight.
- R9: `out_valid` with `out_ready` low keeps `out_valid`, `out_data` and `out_last` unchanged in the next cycle. `out_last` marks the final byte. After each accepted byte there is one idle cycle before the next byte.
- R10: `mem_in_ready` is 0 when the open slot already holds slot-size bytes, and also in the cycle of a launch write made while `req_busy` is 0. A byte offered while `mem_in_ready` is 0 is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_in_valid | input | 1 | Host byte offered to the open slot |
| mem_in_data | input | 8 | Host byte value |
| mem_in_ready | output | 1 | Open slot can take a byte this cycle |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 count low byte, 1 count high byte, 2 control |
| reg_wdata | input | 8 | Register write data; bit 0 is the request bit at address 2 |
| req_busy | output | 1 | Request bit readback, 1 while a packet is in flight |
| out_valid | output | 1 | Outgoing byte valid |
| out_data | output | 8 | Outgoing byte |
| out_last | output | 1 | Outgoing byte is the packet's final byte |
| out_ready | input | 1 | MAC side accepts the byte |
| tx_done | output | 1 | One-cycle pulse after a packet completes |

## Verification
The hardest situation to reach from the ports is overlap: one slot is draining under irregular back-pressure while the host writes into the other slot, rewrites the length registers and issues a second launch that must be ignored. The stimulus throttles `out_ready` to one cycle in three, then performs those writes right after a launch, so they land while the first packet is still held. A cycle-level behavioural model checks every output on every cycle. Separate packet-level checks compare the bytes received against the bytes written. The simultaneous launch-and-write cycle and the full-slot boundary are driven on purpose.

// File: rtl/tx2_pkg.sv
package tx2_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_SHOW  = 2'd2
  } send_state_t;

  localparam logic [1:0] REG_LEN_LO = 2'd0;
  localparam logic [1:0] REG_LEN_HI = 2'd1;
  localparam logic [1:0] REG_CTRL   = 2'd2;
  localparam int         LEN_W      = 16;
  localparam int         BYTE_W     = 8;
endpackage

// File: rtl/tx2_slot_ram.sv
module tx2_slot_ram #(
  parameter int DEPTH  = 3072,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
    if (rd_en) rd_data <= store[rd_addr];
  end
endmodule

// File: rtl/tx2_fill_ctrl.sv
module tx2_fill_ctrl #(
  parameter int SLOT_BYTES = 1536,
  parameter int ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              stall,
  input  logic              launch,
  output logic              in_ready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              fill_slot
);
  localparam int PTR_W = $clog2(SLOT_BYTES + 1);

  logic [PTR_W-1:0] wr_ptr;

  assign in_ready = (wr_ptr < PTR_W'(SLOT_BYTES)) && !stall;
  assign wr_en    = in_valid && in_ready;
  assign wr_addr  = (fill_slot ? ADDR_W'(SLOT_BYTES) : '0) + ADDR_W'(wr_ptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      fill_slot <= 1'b0;
    end else if (launch) begin
      wr_ptr    <= '0;
      fill_slot <= ~fill_slot;
    end else if (wr_en) begin
      wr_ptr <= wr_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/tx2_send_engine.sv
module tx2_send_engine
  import tx2_pkg::*;
#(
  parameter int SLOT_BYTES = 1536,
  parameter int ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic              fill_slot,
  input  logic              out_ready,
  output logic              stall,
  output logic              launch,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              out_valid,
  output logic              out_last,
  output logic              req_busy,
  output logic              tx_done
);
  send_state_t       state;
  logic [BYTE_W-1:0] len_lo, len_hi;
  logic [LEN_W-1:0]  len_now, total, idx;
  logic              send_slot, len_ok, final_byte;

  assign len_now    = {len_hi, len_lo};
  assign len_ok     = (len_now != '0) && (len_now <= LEN_W'(SLOT_BYTES));
  assign req_busy   = (state != ST_IDLE);
  assign stall      = reg_wr_en && (reg_addr == REG_CTRL) && reg_wdata[0] && !req_busy;
  assign launch     = stall && len_ok;
  assign final_byte = (idx == total - 1'b1);

  assign rd_en     = (state == ST_FETCH);
  assign rd_addr   = (send_slot ? ADDR_W'(SLOT_BYTES) : '0) + ADDR_W'(idx);
  assign out_valid = (state == ST_SHOW);
  assign out_last  = out_valid && final_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_lo <= '0;
      len_hi <= '0;
    end else if (reg_wr_en) begin
      if (reg_addr == REG_LEN_LO) len_lo <= reg_wdata;
      if (reg_addr == REG_LEN_HI) len_hi <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      total     <= '0;
      idx       <= '0;
      send_slot <= 1'b0;
      tx_done   <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (launch) begin
            total     <= len_now;
            idx       <= '0;
            send_slot <= fill_slot;
            state     <= ST_FETCH;
          end
        end
        ST_FETCH: state <= ST_SHOW;
        ST_SHOW: begin
          if (out_ready) begin
            if (final_byte) begin
              state   <= ST_IDLE;
              tx_done <= 1'b1;
            end else begin
              idx   <= idx + 1'b1;
              state <= ST_FETCH;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx2_slot_buffer.sv
module tx2_slot_buffer
  import tx2_pkg::*;
#(
  parameter int SLOT_BYTES = 1536
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mem_in_valid,
  input  logic [7:0] mem_in_data,
  output logic       mem_in_ready,
  input  logic       reg_wr_en,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic       req_busy,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last,
  input  logic       out_ready,
  output logic       tx_done
);
  localparam int DEPTH  = 2 * SLOT_BYTES;
  localparam int ADDR_W = $clog2(DEPTH);

  logic              stall, launch, fill_slot, wr_en, rd_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;

  tx2_fill_ctrl #(.SLOT_BYTES(SLOT_BYTES), .ADDR_W(ADDR_W)) u_fill (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (mem_in_valid),
    .stall    (stall),
    .launch   (launch),
    .in_ready (mem_in_ready),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .fill_slot(fill_slot)
  );

  tx2_send_engine #(.SLOT_BYTES(SLOT_BYTES), .ADDR_W(ADDR_W)) u_send (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr_en(reg_wr_en),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .fill_slot(fill_slot),
    .out_ready(out_ready),
    .stall    (stall),
    .launch   (launch),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .out_valid(out_valid),
    .out_last (out_last),
    .req_busy (req_busy),
    .tx_done  (tx_done)
  );

  tx2_slot_ram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_ram (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(mem_in_data),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .rd_data(out_data)
  );
endmodule

// File: rtl/tx2_slot_buffer_chk.sv
module tx2_slot_buffer_chk #(
  parameter int SLOT_BYTES = 1536
) (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr_en,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       mem_in_ready,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       out_ready,
  input logic       req_busy,
  input logic       tx_done
);
  logic [15:0] shadow_len;
  logic        kick, kick_good, kick_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow_len <= '0;
    else if (reg_wr_en && reg_addr == 2'd0) shadow_len[7:0]  <= reg_wdata;
    else if (reg_wr_en && reg_addr == 2'd1) shadow_len[15:8] <= reg_wdata;
  end

  assign kick      = reg_wr_en && (reg_addr == 2'd2) && reg_wdata[0] && !req_busy;
  assign kick_good = kick && (shadow_len != 16'd0) && (shadow_len <= 16'(SLOT_BYTES));
  assign kick_bad  = kick && !kick_good;

  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    kick_good |=> req_busy && !out_valid);
  p_start_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    kick_good |-> ##2 out_valid);
  p_last_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !req_busy && tx_done);
  p_busy_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_busy) |-> tx_done);
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);
  p_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    kick_bad |=> !req_busy && !out_valid && !tx_done);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
  p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid);
  p_launch_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> !mem_in_ready);
endmodule

bind tx2_slot_buffer tx2_slot_buffer_chk #(.SLOT_BYTES(SLOT_BYTES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_en   (reg_wr_en),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .mem_in_ready(mem_in_ready),
  .out_valid   (out_valid),
  .out_data    (out_data),
  .out_last    (out_last),
  .out_ready   (out_ready),
  .req_busy    (req_busy),
  .tx_done     (tx_done)
);

// File: tb/test_tx2_slot_buffer.sv
module test_tx2_slot_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT       = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mem_in_valid = 1'b0;
  logic [7:0] mem_in_data = '0;
  logic       mem_in_ready;
  logic       reg_wr_en = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       req_busy, out_valid, out_last, tx_done;
  logic [7:0] out_data;
  logic       out_ready = 1'b1;

  tx2_slot_buffer #(.SLOT_BYTES(SLOT)) i_tx2_slot_buffer (
    .clk(clk), .rst_n(rst_n),
    .mem_in_valid(mem_in_valid), .mem_in_data(mem_in_data), .mem_in_ready(mem_in_ready),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .req_busy(req_busy), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .out_ready(out_ready), .tx_done(tx_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  bit bp_on = 0;
  int cyc = 0;
  int done_cnt = 0;
  logic [7:0] rx_q[$];
  logic [7:0] exp_q[$];

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_mem [2*SLOT];
  int m_fill, m_ptr, m_phase, m_cnt, m_tot, m_base;
  logic [7:0] m_lo, m_hi, m_byte;
  bit m_done;

  function automatic bit m_kick();
    return reg_wr_en && reg_addr == 2'd2 && reg_wdata[0] && m_phase == 0;
  endfunction

  always @(posedge clk) begin : model
    int len;
    bit kk, ok, wr;
    if (!rst_n) begin
      m_fill = 0; m_ptr = 0; m_phase = 0; m_cnt = 0; m_tot = 0; m_base = 0;
      m_lo = 0; m_hi = 0; m_done = 0;
    end else begin
      len = {m_hi, m_lo};
      kk  = m_kick();
      ok  = (len != 0) && (len <= SLOT);
      wr  = mem_in_valid && (m_ptr < SLOT) && !kk;
      m_done = 0;
      case (m_phase)
        0: if (kk && ok) begin
             m_phase = 1; m_tot = len; m_cnt = 0; m_base = m_fill * SLOT;
           end
        1: begin m_byte = m_mem[m_base + m_cnt]; m_phase = 2; end
        default: if (out_ready) begin
             if (m_cnt == m_tot - 1) begin m_phase = 0; m_done = 1; end
             else begin m_cnt++; m_phase = 1; end
           end
      endcase
      if (wr) begin m_mem[m_fill * SLOT + m_ptr] = mem_in_data; m_ptr++; end
      if (kk && ok) begin m_fill = 1 - m_fill; m_ptr = 0; end
      if (reg_wr_en && reg_addr == 2'd0) m_lo = reg_wdata;
      if (reg_wr_en && reg_addr == 2'd1) m_hi = reg_wdata;
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      chk(req_busy === (m_phase != 0), "R5", "req_busy", req_busy, m_phase != 0);
      chk(tx_done === m_done, "R5", "tx_done", tx_done, m_done);
      chk(out_valid === (m_phase == 2), "R9", "out_valid", out_valid, m_phase == 2);
      if (m_phase == 2) begin
        chk(out_data === m_byte, "R9", "out_data", out_data, m_byte);
        chk(out_last === (m_cnt == m_tot - 1), "R9", "out_last", out_last, m_cnt == m_tot - 1);
      end
      chk(mem_in_ready === ((m_ptr < SLOT) && !m_kick()), "R10", "mem_in_ready",
          mem_in_ready, (m_ptr < SLOT) && !m_kick());
    end
  end

  // ---------------- stimulus helpers ----------------
  always @(negedge clk) begin
    cyc++;
    out_ready = bp_on ? (cyc % 3 == 0) : 1'b1;
  end

  always @(negedge clk) begin
    #(CLK_PERIOD/2 - 1);
    if (rst_n && out_valid && out_ready) rx_q.push_back(out_data);
    if (rst_n && tx_done) done_cnt++;
  end

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic set_len(input int n);
    reg_wr(2'd0, n[7:0]);
    reg_wr(2'd1, n[15:8]);
  endtask

  task automatic push(input logic [7:0] d, output bit acc);
    mem_in_valid = 1'b1; mem_in_data = d;
    #1 acc = mem_in_ready;
    @(negedge clk);
    mem_in_valid = 1'b0;
  endtask

  task automatic fill(input int n, input int seed);
    bit acc;
    exp_q.delete();
    for (int i = 0; i < n; i++) begin
      push(8'(seed + 7 * i), acc);
      exp_q.push_back(8'(seed + 7 * i));
    end
  endtask

  task automatic wait_idle();
    while (req_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_pkt(input string rq, input logic [7:0] e[$]);
    chk(rx_q.size() == e.size(), rq, "packet length", rx_q.size(), e.size());
    for (int i = 0; i < e.size() && i < rx_q.size(); i++)
      chk(rx_q[i] === e[i], rq, "packet byte", rx_q[i], e[i]);
    rx_q.delete();
  endtask

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R5 watchdog: actual busy expected idle");
    finish_run();
  end

  initial begin
    logic [7:0] pkt_a[$];
    logic [7:0] pkt_b[$];
    int d0;
    bit acc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_busy == 0, "R1", "req_busy after reset", req_busy, 0);
    chk(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    chk(tx_done == 0, "R1", "tx_done after reset", tx_done, 0);
    chk(mem_in_ready == 1, "R1", "mem_in_ready after reset", mem_in_ready, 1);

    // R3 R4 R8: slot 0 sent under back-pressure while slot 1 is filled
    fill(5, 8'h10); pkt_a = exp_q;
    set_len(5);
    bp_on = 1;
    reg_wr(2'd2, 8'h01);
    chk(req_busy == 1, "R3", "busy after launch", req_busy, 1);
    reg_wr(2'd0, 8'd2);
    reg_wr(2'd2, 8'h01);
    fill(7, 8'h40); pkt_b = exp_q;
    wait_idle();
    check_pkt("R4", pkt_a);
    chk(done_cnt == 1, "R5", "done pulses", done_cnt, 1);

    // R7 R8: second slot holds the bytes written during the first send
    bp_on = 0;
    set_len(7);
    reg_wr(2'd2, 8'h01);
    wait_idle();
    check_pkt("R8", pkt_b);
    chk(done_cnt == 2, "R5", "done pulses", done_cnt, 2);

    // R7: back to slot 0 with new content
    fill(3, 8'h80); pkt_a = exp_q;
    set_len(3);
    bp_on = 1;
    reg_wr(2'd2, 8'h01);
    wait_idle();
    check_pkt("R7", pkt_a);
    bp_on = 0;

    // R2 R6: 258 is over the slot size, 0 is empty
    d0 = done_cnt;
    reg_wr(2'd0, 8'd2); reg_wr(2'd1, 8'd1);
    reg_wr(2'd2, 8'h01);
    chk(req_busy == 0, "R6", "busy after oversize", req_busy, 0);
    repeat (6) @(negedge clk);
    chk(rx_q.size() == 0, "R2", "bytes after 258 launch", rx_q.size(), 0);
    set_len(0);
    reg_wr(2'd2, 8'h01);
    chk(req_busy == 0, "R6", "busy after zero", req_busy, 0);
    repeat (6) @(negedge clk);
    chk(rx_q.size() == 0, "R6", "bytes after zero launch", rx_q.size(), 0);
    chk(done_cnt == d0, "R6", "done pulses after refusals", done_cnt, d0);

    // R10: fill slot 1 completely, extra byte refused; R6 above-size by one
    fill(SLOT, 8'h03); pkt_b = exp_q;
    push(8'hEE, acc);
    chk(acc == 0, "R10", "byte accepted into full slot", acc, 0);
    set_len(SLOT + 1);
    reg_wr(2'd2, 8'h01);
    chk(req_busy == 0, "R6", "busy after slot+1", req_busy, 0);
    set_len(SLOT);
    reg_wr(2'd2, 8'h01);
    wait_idle();
    check_pkt("R10", pkt_b);

    // R10: byte offered in the launch cycle is not stored
    fill(1, 8'hC1); pkt_a = exp_q;
    set_len(1);
    mem_in_valid = 1'b1; mem_in_data = 8'h77;
    reg_wr_en = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h01;
    #1 chk(mem_in_ready == 0, "R10", "ready in launch cycle", mem_in_ready, 0);
    @(negedge clk);
    mem_in_valid = 1'b0; reg_wr_en = 1'b0;
    wait_idle();
    check_pkt("R3", pkt_a);
    chk(done_cnt == d0 + 2, "R5", "done pulses total", done_cnt, d0 + 2);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule